// File: doc/BRIEF.md
# Host Target Register Access Sequencer

This block sits between a host bus bridge working in target (pass-through) mode and a field of peripheral devices on several boards. When the bridge signals an active target cycle and target service is enabled, the sequencer requests the host address, latches it, and decodes it into one of four equal regions of a 32 KB window. One region reaches the register devices, one reaches the lookup-table loaders, and the other two are unused. It then runs the handshake that fits the chosen device and pulses a data-ready strobe back to the bridge as each word completes.

Register devices use a ready handshake. Chip select stays asserted with a read or write strobe until the device raises its ready output. Burst writes advance the register index after every word. Lookup-table loaders have no address lines. A table read returns its data after one fixed wait. A table write waits for the loader's data-request flag, lets a fixed settling delay pass, and then issues back-to-back one-cycle write strobes, up to seven for each table entry.

The controller states are IDLE, LATCH, RREG, RTBL, RTBL_WAIT, RDONE, SETTLE, WGAP, WHOLD, WDONE, TDLY, TWR and NULL. The transitions are:
- IDLE→LATCH on start.
- LATCH→RREG on a register read.
- LATCH→RTBL on a table read.
- LATCH→WGAP on a register write.
- LATCH→TDLY on a table write once the data-request flag is seen; LATCH→LATCH while the table write waits for it.
- LATCH→NULL for an unused region.
- RREG→RDONE on device ready.
- RTBL→RTBL_WAIT→RDONE.
- RDONE→SETTLE→IDLE.
- WGAP→WHOLD.
- WHOLD→WDONE on device ready.
- WDONE→WHOLD while burst is held, otherwise WDONE→IDLE.
- TDLY→TWR after the delay.
- TWR→TWR while burst is held and fewer than seven writes have been made, otherwise TWR→IDLE.
- NULL→IDLE.

Top module: `host_tgt_seq`

## Requirements
- R1: After reset the block is idle. addr_req, data_rdy, dev_cs, every read and write strobe and host_rdata are all zero.
- R2: A transaction starts only when tgt_active and tgt_en are both high. tgt_dir_wr selects the direction (0 read, 1 write). addr_req is high for exactly one cycle, combinationally, in the idle cycle that starts the transaction.
- R3: Address decode works as follows:
  - host_addr[14:13] picks the region: 0 is register devices, 1 is table loaders, 2 and 3 are unused.
  - brd_sel equals host_addr[12:10].
  - sub_sel equals {1 for a table loader and 0 for a register device, host_addr[9]}.
  - reg_addr equals host_addr[8:2].
  - At most one of reg_rd, reg_wr, tbl_rd and tbl_wr is high in any cycle.
- R4: A register read holds dev_cs and reg_rd until reg_ready is sampled high. In that cycle dev_rdata is captured. data_rdy is high for the next cycle with host_rdata showing the captured word, and one quiet settle cycle follows before idle. When start is seen at clock edge 0, data_rdy appears in cycle 2+L, where ready is first sampled in the L-th strobe cycle.
- R5: A table read asserts dev_cs and tbl_rd for exactly two cycles (strobe plus one wait). It captures dev_rdata at the end of the wait, and data_rdy follows in the next cycle.
- R6: A register write spends one idle gap cycle after the latch cycle, so reg_wr first appears in the third cycle after start. reg_wr and dev_cs stay asserted, with dev_wdata equal to host_wdata, until reg_ready is sampled high. data_rdy then pulses and reg_addr increases by one.
- R7: After each register-write data_rdy, another word is written to the incremented index if tgt_burst is high. If tgt_burst is low the block returns to idle.
- R8: A table write waits in LATCH with dev_cs low until tbl_dreq is sampled high. Three settle cycles follow. The writes then run in consecutive cycles, each with tbl_wr, dev_cs and data_rdy high for one cycle and dev_wdata equal to host_wdata.
- R9: A table write sequence ends after seven writes, or after the first write in which tgt_burst is sampled low, whichever comes first.
- R10: An access to an unused region never asserts dev_cs. It pulses data_rdy in the second cycle after start with host_rdata zero, for both reads and writes.
- R11: host_addr[1:0] do not affect the decode or the device index.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| tgt_active | input | 1 | Host target cycle in progress |
| tgt_en | input | 1 | Target service enabled |
| tgt_dir_wr | input | 1 | Direction, 1 for write, 0 for read |
| tgt_burst | input | 1 | Host wants another word after this one |
| host_addr | input | 15 | Host byte address within the window |
| host_wdata | input | 32 | Host write data |
| addr_req | output | 1 | Request for the host address |
| data_rdy | output | 1 | Word complete strobe to host |
| host_rdata | output | 32 | Read data to host |
| dev_cs | output | 1 | Device chip select |
| brd_sel | output | 3 | Board select |
| sub_sel | output | 2 | Device select within a board |
| reg_addr | output | 7 | Register index in the device |
| reg_rd | output | 1 | Register device read strobe |
| reg_wr | output | 1 | Register device write strobe |
| tbl_rd | output | 1 | Table loader read strobe |
| tbl_wr | output | 1 | Table loader write strobe |
| dev_wdata | output | 32 | Write data to device |
| dev_rdata | input | 32 | Read data from device |
| reg_ready | input | 1 | Register device ready |
| tbl_dreq | input | 1 | Table loader data request |

## Verification
The hardest situation to reach from the ports is a table-write sequence that ends on its own count rather than on the host. That needs tbl_dreq withheld for a while and tgt_burst held across every strobe, so the bench keeps the burst request up until seven consecutive strobes have passed. A second run drops burst after the third strobe. Register bursts are driven with varying ready latencies so that the index increment is seen on a fresh strobe cycle. Reads from every region are walked from a vector table, including addresses whose low two bits are nonzero.

// File: rtl/hts_pkg.sv
`timescale 1ns/1ps
package hts_pkg;

    typedef enum logic [3:0] {
        S_IDLE      = 4'd0,
        S_LATCH     = 4'd1,
        S_RREG      = 4'd2,
        S_RTBL      = 4'd3,
        S_RTBL_WAIT = 4'd4,
        S_RDONE     = 4'd5,
        S_SETTLE    = 4'd6,
        S_WGAP      = 4'd7,
        S_WHOLD     = 4'd8,
        S_WDONE     = 4'd9,
        S_TDLY      = 4'd10,
        S_TWR       = 4'd11,
        S_NULL      = 4'd12
    } hts_state_e;

    typedef enum logic [1:0] {
        KIND_REG  = 2'd0,
        KIND_TBL  = 2'd1,
        KIND_NONE = 2'd2
    } hts_kind_e;

endpackage

// File: rtl/hts_addr_decode.sv
`timescale 1ns/1ps
module hts_addr_decode
    import hts_pkg::*;
#(
    parameter int ADDR_W = 15,
    parameter int BLK_W  = 2,
    parameter int BRD_W  = 3,
    parameter int IDX_W  = 7
) (
    input  logic [ADDR_W-1:0] addr,
    output hts_kind_e         kind,
    output logic [BRD_W-1:0]  brd,
    output logic              sub_lo,
    output logic [IDX_W-1:0]  idx
);
    localparam int IDX_LO = 2;
    localparam int SUB_B  = IDX_LO + IDX_W;
    localparam int BRD_LO = SUB_B + 1;
    localparam int BLK_LO = ADDR_W - BLK_W;

    logic [BLK_W-1:0] blk;
    logic [1:0]       unused_lsb;

    assign blk        = addr[BLK_LO +: BLK_W];
    assign brd        = addr[BRD_LO +: BRD_W];
    assign sub_lo     = addr[SUB_B];
    assign idx        = addr[IDX_LO +: IDX_W];
    assign unused_lsb = addr[1:0];

    always_comb begin
        if (blk == BLK_W'(0))      kind = KIND_REG;
        else if (blk == BLK_W'(1)) kind = KIND_TBL;
        else                       kind = KIND_NONE;
    end

endmodule

// File: rtl/hts_tbl_counter.sv
`timescale 1ns/1ps
module hts_tbl_counter #(
    parameter int WR_MAX  = 7,
    parameter int DLY_CYC = 3
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clr,
    input  logic dly_step,
    input  logic wr_step,
    output logic dly_done,
    output logic wr_last
);
    localparam int CNT_W = $clog2(WR_MAX + 1);
    localparam int DLY_W = $clog2(DLY_CYC + 1);

    logic [CNT_W-1:0] wr_cnt_q;
    logic [DLY_W-1:0] dly_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            wr_cnt_q <= '0;
            dly_q    <= '0;
        end else if (clr) begin
            wr_cnt_q <= '0;
            dly_q    <= '0;
        end else begin
            if (dly_step) dly_q    <= dly_q + 1'b1;
            if (wr_step)  wr_cnt_q <= wr_cnt_q + 1'b1;
        end
    end

    assign dly_done = (dly_q == DLY_W'(DLY_CYC - 1));
    assign wr_last  = (wr_cnt_q == CNT_W'(WR_MAX - 1));

    AST_WR_CNT_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        wr_step |-> (wr_cnt_q < CNT_W'(WR_MAX))); // R9
    AST_DLY_BEFORE_WR: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(wr_step) |-> $past(dly_done)); // R8

endmodule

// File: rtl/host_tgt_seq.sv
`timescale 1ns/1ps
module host_tgt_seq
    import hts_pkg::*;
#(
    parameter int ADDR_W  = 15,
    parameter int DATA_W  = 32,
    parameter int BRD_W   = 3,
    parameter int IDX_W   = 7,
    parameter int TBL_WR  = 7,
    parameter int TBL_DLY = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tgt_active,
    input  logic              tgt_en,
    input  logic              tgt_dir_wr,
    input  logic              tgt_burst,
    input  logic [ADDR_W-1:0] host_addr,
    input  logic [DATA_W-1:0] host_wdata,
    output logic              addr_req,
    output logic              data_rdy,
    output logic [DATA_W-1:0] host_rdata,
    output logic              dev_cs,
    output logic [BRD_W-1:0]  brd_sel,
    output logic [1:0]        sub_sel,
    output logic [IDX_W-1:0]  reg_addr,
    output logic              reg_rd,
    output logic              reg_wr,
    output logic              tbl_rd,
    output logic              tbl_wr,
    output logic [DATA_W-1:0] dev_wdata,
    input  logic [DATA_W-1:0] dev_rdata,
    input  logic              reg_ready,
    input  logic              tbl_dreq
);
    localparam int BLK_W = 2;

    hts_state_e state_q, state_d;
    hts_kind_e  dec_kind, kind_q;
    logic [BRD_W-1:0] dec_brd, brd_q;
    logic             dec_sub, sub_q;
    logic [IDX_W-1:0] dec_idx, idx_q;
    logic [DATA_W-1:0] rdata_q;
    logic start, dly_done, wr_last;

    hts_addr_decode #(
        .ADDR_W(ADDR_W), .BLK_W(BLK_W), .BRD_W(BRD_W), .IDX_W(IDX_W)
    ) u_dec (
        .addr(host_addr), .kind(dec_kind), .brd(dec_brd),
        .sub_lo(dec_sub), .idx(dec_idx)
    );

    hts_tbl_counter #(.WR_MAX(TBL_WR), .DLY_CYC(TBL_DLY)) u_cnt (
        .clk(clk), .rst_n(rst_n),
        .clr(state_q == S_LATCH),
        .dly_step(state_q == S_TDLY),
        .wr_step(state_q == S_TWR),
        .dly_done(dly_done),
        .wr_last(wr_last)
    );

    assign start = tgt_active && tgt_en;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= S_IDLE;
        else        state_q <= state_d;
    end

    // next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            S_IDLE:      if (start) state_d = S_LATCH;
            S_LATCH: begin
                unique case (dec_kind)
                    KIND_REG: state_d = tgt_dir_wr ? S_WGAP : S_RREG;
                    KIND_TBL: begin
                        if (!tgt_dir_wr)   state_d = S_RTBL;
                        else if (tbl_dreq) state_d = S_TDLY;
                    end
                    default:  state_d = S_NULL;
                endcase
            end
            S_RREG:      if (reg_ready) state_d = S_RDONE;
            S_RTBL:      state_d = S_RTBL_WAIT;
            S_RTBL_WAIT: state_d = S_RDONE;
            S_RDONE:     state_d = S_SETTLE;
            S_SETTLE:    state_d = S_IDLE;
            S_WGAP:      state_d = S_WHOLD;
            S_WHOLD:     if (reg_ready) state_d = S_WDONE;
            S_WDONE:     state_d = tgt_burst ? S_WHOLD : S_IDLE;
            S_TDLY:      if (dly_done) state_d = S_TWR;
            S_TWR:       if (wr_last || !tgt_burst) state_d = S_IDLE;
            S_NULL:      state_d = S_IDLE;
            default:     state_d = S_IDLE;
        endcase
    end

    // address and read datapath
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            kind_q  <= KIND_NONE;
            brd_q   <= '0;
            sub_q   <= 1'b0;
            idx_q   <= '0;
            rdata_q <= '0;
        end else begin
            unique case (state_q)
                S_LATCH: begin
                    kind_q  <= dec_kind;
                    brd_q   <= dec_brd;
                    sub_q   <= dec_sub;
                    idx_q   <= dec_idx;
                    rdata_q <= '0;
                end
                S_RREG:      if (reg_ready) rdata_q <= dev_rdata;
                S_RTBL_WAIT: rdata_q <= dev_rdata;
                S_WHOLD:     if (reg_ready) idx_q <= idx_q + 1'b1;
                default: ;
            endcase
        end
    end

    // outputs
    always_comb begin
        addr_req  = (state_q == S_IDLE) && start;
        dev_cs    = 1'b0;
        reg_rd    = 1'b0;
        reg_wr    = 1'b0;
        tbl_rd    = 1'b0;
        tbl_wr    = 1'b0;
        data_rdy  = 1'b0;
        dev_wdata = '0;
        unique case (state_q)
            S_RREG:      begin dev_cs = 1'b1; reg_rd = 1'b1; end
            S_RTBL,
            S_RTBL_WAIT: begin dev_cs = 1'b1; tbl_rd = 1'b1; end
            S_WHOLD:     begin dev_cs = 1'b1; reg_wr = 1'b1; dev_wdata = host_wdata; end
            S_TWR:       begin dev_cs = 1'b1; tbl_wr = 1'b1; data_rdy = 1'b1; dev_wdata = host_wdata; end
            S_RDONE,
            S_WDONE,
            S_NULL:      data_rdy = 1'b1;
            default: ;
        endcase
    end

    assign host_rdata = rdata_q;
    assign brd_sel    = brd_q;
    assign sub_sel    = {kind_q == KIND_TBL, sub_q};
    assign reg_addr   = idx_q;

    AST_REQ_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        addr_req |=> !addr_req); // R2
    AST_STROBE_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({reg_rd, reg_wr, tbl_rd, tbl_wr})); // R3
    AST_RDY_AFTER_READY: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_rd && reg_ready) |=> (data_rdy && !dev_cs)); // R4
    AST_SETTLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        (data_rdy && state_q == S_RDONE) |=> (!data_rdy && !dev_cs)); // R4
    AST_TBL_RD_WAIT: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(tbl_rd) |=> tbl_rd ##1 (!tbl_rd && data_rdy)); // R5
    AST_ADDR_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_wr && reg_ready) |=> (reg_addr == $past(reg_addr) + 1'b1)); // R6
    AST_TBL_WR_RDY: assert property (@(posedge clk) disable iff (!rst_n)
        tbl_wr |-> (data_rdy && dev_cs)); // R8
    AST_NULL_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == S_NULL) |-> (!dev_cs && host_rdata == '0)); // R10

endmodule

// File: tb/host_tgt_seq_bench.sv
`timescale 1ns/1ps
module host_tgt_seq_bench;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        tgt_active, tgt_en, tgt_dir_wr, tgt_burst;
    logic [14:0] host_addr;
    logic [31:0] host_wdata;
    logic        addr_req, data_rdy;
    logic [31:0] host_rdata;
    logic        dev_cs;
    logic [2:0]  brd_sel;
    logic [1:0]  sub_sel;
    logic [6:0]  reg_addr;
    logic        reg_rd, reg_wr, tbl_rd, tbl_wr;
    logic [31:0] dev_wdata, dev_rdata;
    logic        reg_ready, tbl_dreq;

    int n_tests = 0;
    int n_fail  = 0;
    bit done    = 1'b0;

    always #2.5 clk = ~clk;

    host_tgt_seq u_host_tgt_seq (
        .clk(clk), .rst_n(rst_n), .tgt_active(tgt_active), .tgt_en(tgt_en),
        .tgt_dir_wr(tgt_dir_wr), .tgt_burst(tgt_burst), .host_addr(host_addr),
        .host_wdata(host_wdata), .addr_req(addr_req), .data_rdy(data_rdy),
        .host_rdata(host_rdata), .dev_cs(dev_cs), .brd_sel(brd_sel),
        .sub_sel(sub_sel), .reg_addr(reg_addr), .reg_rd(reg_rd), .reg_wr(reg_wr),
        .tbl_rd(tbl_rd), .tbl_wr(tbl_wr), .dev_wdata(dev_wdata),
        .dev_rdata(dev_rdata), .reg_ready(reg_ready), .tbl_dreq(tbl_dreq)
    );

    // {addr[14:0], ready latency[3:0], device data[31:0]}
    localparam logic [50:0] VEC [6] = '{
        {2'b00, 3'd5, 1'b1, 7'h2A, 2'b00, 4'd1, 32'hDEAD_0001},
        {2'b00, 3'd0, 1'b0, 7'h00, 2'b00, 4'd4, 32'h1234_5678},
        {2'b00, 3'd7, 1'b1, 7'h7F, 2'b11, 4'd2, 32'hCAFE_F00D},
        {2'b01, 3'd3, 1'b0, 7'h05, 2'b10, 4'd0, 32'h0BAD_BEEF},
        {2'b10, 3'd1, 1'b1, 7'h11, 2'b00, 4'd0, 32'h5555_AAAA},
        {2'b11, 3'd6, 1'b0, 7'h33, 2'b01, 4'd0, 32'h7777_1111}
    };

    task automatic check(input bit ok, input string req, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    task automatic do_read(input logic [50:0] v);
        logic [14:0] a;
        logic [3:0]  lat;
        logic [31:0] d, rd, exp_rd;
        logic [2:0]  f_brd;
        logic [1:0]  f_sub;
        logic [6:0]  f_idx;
        int k, got, exp_cyc;
        bit saw_cs;
        string rq;
        a = v[50:36]; lat = v[35:32]; d = v[31:0];
        k = 0; got = -1; saw_cs = 0; rd = '0;
        f_brd = '0; f_sub = '0; f_idx = '0;
        exp_cyc = (a[14:13] == 2'd0) ? 2 + int'(lat) : (a[14:13] == 2'd1) ? 4 : 2;
        exp_rd  = (a[14:13] >= 2'd2) ? 32'h0 : d;
        rq = (a[14:13] == 2'd0) ? "R4" : (a[14:13] == 2'd1) ? "R5" : "R10";
        @(negedge clk);
        dev_rdata = d; host_addr = a; tgt_dir_wr = 1'b0; tgt_active = 1'b1;
        #1;
        check(addr_req === 1'b1, "R2", "addr_req at start", {31'b0, addr_req}, 32'h1);
        for (int c = 1; c <= 40; c++) begin
            @(negedge clk);
            if (dev_cs) begin
                saw_cs = 1; f_brd = brd_sel; f_sub = sub_sel; f_idx = reg_addr;
            end
            if (reg_rd && dev_cs) begin
                k++;
                if (k == int'(lat)) reg_ready = 1'b1;
            end
            if (data_rdy) begin
                got = c; rd = host_rdata; reg_ready = 1'b0; tgt_active = 1'b0;
                break;
            end
        end
        check(got == exp_cyc, rq, "data_rdy cycle", got, exp_cyc);
        check(rd === exp_rd, rq, "read data", rd, exp_rd);
        if (a[14:13] < 2'd2) begin
            check(saw_cs && f_brd == a[12:10] && f_sub == {a[14:13] == 2'd1, a[9]}
                  && f_idx == a[8:2], (a[1:0] != 0) ? "R11" : "R3", "device select",
                  {18'b0, f_brd, f_sub, f_idx, 2'b0}, {18'b0, a[12:10], a[14:13] == 2'd1, a[9], a[8:2], 2'b0});
        end else begin
            check(!saw_cs, "R10", "no chip select on unused region", {31'b0, saw_cs}, 32'h0);
        end
        @(negedge clk);
        check(!data_rdy && !dev_cs, rq, "quiet cycle after data_rdy", {30'b0, data_rdy, dev_cs}, 32'h0);
        @(negedge clk);
    endtask

    task automatic reg_write(input logic [14:0] a, input int n, input int lat);
        int w, k, first;
        bit ok_d, ok_a;
        w = 0; k = 0; first = -1; ok_d = 1; ok_a = 1;
        @(negedge clk);
        host_addr = a; tgt_dir_wr = 1'b1; tgt_burst = (n > 1);
        host_wdata = 32'hA500_0000; tgt_active = 1'b1;
        for (int c = 1; c <= 100; c++) begin
            @(negedge clk);
            if (reg_wr && dev_cs) begin
                if (first < 0) first = c;
                k++;
                if (dev_wdata !== host_wdata) ok_d = 0;
                if (reg_addr !== 7'(a[8:2] + w)) ok_a = 0;
                if (k == lat) reg_ready = 1'b1;
            end
            if (data_rdy) begin
                w++; k = 0; reg_ready = 1'b0; host_wdata = host_wdata + 1;
                tgt_burst = (w < n);
                if (w == n) begin
                    tgt_active = 1'b0;
                    break;
                end
            end
        end
        check(first == 3, "R6", "first write strobe cycle", first, 3);
        check(ok_d, "R6", "write data on device", {31'b0, ok_d}, 32'h1);
        check(ok_a, "R6", "register index per word", {31'b0, ok_a}, 32'h1);
        check(w == n, "R7", "burst word count", w, n);
        @(negedge clk);
        check(!reg_wr && !dev_cs, "R7", "stopped after burst", {30'b0, reg_wr, dev_cs}, 32'h0);
        @(negedge clk);
    endtask

    task automatic tbl_write(input logic [14:0] a, input int dly, input int stop_at);
        int nw, first, last, exp_n;
        bit gap_ok, pre_ok, ok_d;
        nw = 0; first = -1; last = -1; gap_ok = 1; pre_ok = 1; ok_d = 1;
        exp_n = (stop_at < 7) ? stop_at : 7;
        @(negedge clk);
        host_addr = a; tgt_dir_wr = 1'b1; tgt_burst = 1'b1; tbl_dreq = 1'b0;
        host_wdata = 32'h7B00_0000; tgt_active = 1'b1;
        for (int c = 1; c <= 60; c++) begin
            @(negedge clk);
            if (c <= dly && dev_cs) pre_ok = 0;
            if (c == dly) tbl_dreq = 1'b1;
            if (tbl_wr) begin
                tbl_dreq = 1'b0;
                if (first < 0) first = c;
                else if (c != last + 1) gap_ok = 0;
                last = c;
                if (!data_rdy || !dev_cs || dev_wdata !== host_wdata) ok_d = 0;
                nw++; host_wdata = host_wdata + 1;
                if (nw == stop_at) tgt_burst = 1'b0;
            end else if (nw > 0) begin
                break;
            end
        end
        tgt_active = 1'b0; tgt_burst = 1'b0;
        check(pre_ok, "R8", "no select before data request", {31'b0, pre_ok}, 32'h1);
        check(first == dly + 4, "R8", "first table write cycle", first, dly + 4);
        check(gap_ok && ok_d, "R8", "consecutive strobes with data_rdy", {30'b0, gap_ok, ok_d}, 32'h3);
        check(nw == exp_n, "R9", "table write count", nw, exp_n);
        check(!dev_cs, "R9", "idle after sequence", {31'b0, dev_cs}, 32'h0);
        @(negedge clk);
    endtask

    initial begin
        int got;
        rst_n = 1'b0; tgt_active = 1'b0; tgt_en = 1'b1; tgt_dir_wr = 1'b0;
        tgt_burst = 1'b0; host_addr = '0; host_wdata = '0; dev_rdata = '0;
        reg_ready = 1'b0; tbl_dreq = 1'b0;
        repeat (3) @(negedge clk);
        check({addr_req, data_rdy, dev_cs, reg_rd, reg_wr, tbl_rd, tbl_wr} == 7'b0 && host_rdata == 0,
              "R1", "outputs in reset", {25'b0, addr_req, data_rdy, dev_cs, reg_rd, reg_wr, tbl_rd, tbl_wr}, 32'h0);
        rst_n = 1'b1;
        @(negedge clk);
        check(!dev_cs && !data_rdy && host_rdata == 0, "R1", "idle after reset", host_rdata, 32'h0);

        // target disabled: nothing starts
        tgt_en = 1'b0; tgt_active = 1'b1; host_addr = 15'h0004;
        for (int c = 0; c < 4; c++) begin
            #1;
            check(!addr_req && !dev_cs, "R2", "no start while disabled", {30'b0, addr_req, dev_cs}, 32'h0);
            @(negedge clk);
        end
        tgt_active = 1'b0; tgt_en = 1'b1;
        @(negedge clk);

        for (int i = 0; i < 6; i++) do_read(VEC[i]);

        reg_write({2'b00, 3'd2, 1'b0, 7'h10, 2'b00}, 1, 2);
        reg_write({2'b00, 3'd4, 1'b1, 7'h7E, 2'b00}, 3, 1);

        tbl_write({2'b01, 3'd1, 1'b1, 7'h00, 2'b00}, 3, 9);
        tbl_write({2'b01, 3'd6, 1'b0, 7'h00, 2'b00}, 1, 3);
        tbl_write({2'b01, 3'd0, 1'b1, 7'h00, 2'b00}, 2, 1);

        // write to unused region
        @(negedge clk);
        host_addr = {2'b11, 13'h0040}; tgt_dir_wr = 1'b1; tgt_active = 1'b1;
        got = -1;
        for (int c = 1; c <= 10; c++) begin
            @(negedge clk);
            if (dev_cs) got = -2;
            if (data_rdy && got == -1) begin
                got = c; tgt_active = 1'b0;
                break;
            end
        end
        check(got == 2, "R10", "unused-region write completion", got, 2);

        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_tests++; n_fail++;
            $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

endmodule